// File: doc/BRIEF.md
# Serial-Load Shift Register with Output Holding Register

This block receives a bit stream from a serial host and presents it as a parallel word. Each rising edge of a shift strobe pushes the serial input into the first stage of a chain of stages. A separate latch strobe copies the whole chain into a holding register, and that register drives the parallel bus. Because the two strobes are independent, the host can shift a new word in while the parallel outputs keep showing the previous one. It then commits the new word with a single latch edge.

The last stage of the chain is brought out as a serial tap, so several units can be cascaded into a longer chain. A dedicated active-low clear empties the chain at once and leaves the holding register alone. An active-low output enable controls a per-bit drive-enable vector for the parallel bus. The tri-state buffers themselves belong to the top level. The serial tap is never gated by the output enable.

Everything runs in one system-clock domain. The two strobe inputs and the serial data input pass through matched synchronizer pipelines, and each strobe is turned into a single-cycle pulse on its rising edge.

Top module: `shreg_latch`

## Requirements
- R1: On each detected rising edge of `shift_strobe`, stage 0 (stage A) takes `ser_in` and every stage i moves its value into stage i+1.
- R2: While `clr_n` is low, all shift stages are zero, without waiting for a clock edge; the holding register and `par_data` keep their value.
- R3: On each detected rising edge of `latch_strobe`, all stages are copied into the holding register in parallel; with no latch edge the holding register keeps its value.
- R4: `par_data[i]` equals holding-register bit i, with bit 0 being stage A. `par_drive` is all ones when `oe_n` is low and all zeros when `oe_n` is high.
- R5: `ser_out` always equals the last stage. That is the bit shifted in WIDTH shift edges earlier, or 0 if fewer edges have occurred since a clear. It does not depend on `oe_n`.
- R6: When both strobes rise in the same cycle, the holding register captures the chain contents from before that shift.
- R7: Shift edges detected while `clr_n` is low are ignored. After release, the chain moves only on a later rising edge.
- R8: A synchronous low on `rst_n` zeroes the shift stages and the holding register.
- R9: A strobe held high produces exactly one shift or latch, however long it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset of the whole block |
| clr_n | input | 1 | Asynchronous active-low clear of the shift stages only |
| ser_in | input | 1 | Serial data input |
| shift_strobe | input | 1 | Shift strobe, acts on its rising edge |
| latch_strobe | input | 1 | Latch strobe, acts on its rising edge |
| oe_n | input | 1 | Active-low enable for the parallel bus drivers |
| par_data | output | WIDTH | Holding-register contents, bit 0 = stage A |
| par_drive | output | WIDTH | Per-bit drive enable for the parallel bus |
| ser_out | output | 1 | Last shift stage, for cascading |

## Verification
The bench builds the block with its defaults: WIDTH = 8 and SYNC_STAGES = 2. With eight stages, a full word lands on `par_data` in a form that is easy to read as a byte, so several patterns can be walked from a table. A two-flop synchronizer makes each strobe act three clock edges after it rises. This leaves room to hold a strobe high for many cycles and confirm that only one pulse results. It also lets both strobes rise in the same cycle, and lets a clear overlap a strobe edge.

// File: rtl/shreg_pkg.sv
// Shared defaults and helpers for the serial-load shift register block.
// Assumes nothing beyond a single system clock domain.
package shreg_pkg;
    localparam int DEF_WIDTH       = 8;
    localparam int DEF_SYNC_STAGES = 2;

    // Build a drive-enable mask: all ones when enabled, else all zeros.
    function automatic logic [DEF_WIDTH-1:0] drive_mask(input logic enable);
        drive_mask = enable ? '1 : '0;
    endfunction
endpackage

// File: rtl/strobe_sync.sv
// Brings an asynchronous strobe into the clock domain through STAGES flops
// and emits a one-cycle pulse for each rising edge seen at the last flop.
// Assumes the strobe stays high and low for more than one clock period.
module strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_in,
    output logic pulse
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First synchronizer flop samples the raw strobe.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= strobe_in;
                end
            end else begin : g_next
                // Later flops settle the sampled strobe.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    // Remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    // Rising edge of the synchronized level.
    assign pulse = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/bit_delay.sv
// Delays a single data bit by DEPTH clock cycles so that it lines up with a
// strobe that travels through a synchronizer of the same depth.
// Assumes the data is stable at the clock edge where the strobe is sampled.
module bit_delay #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [DEPTH-1:0] pipe_q;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_tap
            if (g == 0) begin : g_first
                // Capture the incoming bit.
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe_q[0] <= 1'b0;
                    else        pipe_q[0] <= d_in;
                end
            end else begin : g_next
                // Carry the bit one cycle further.
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe_q[g] <= 1'b0;
                    else        pipe_q[g] <= pipe_q[g-1];
                end
            end
        end
    endgenerate

    assign d_out = pipe_q[DEPTH-1];
endmodule

// File: rtl/shift_chain.sv
// WIDTH-stage serial shift chain. Stage 0 takes the serial bit on shift_en and
// each stage passes its value upward. An asynchronous active-low clear
// empties every stage and overrides shifting. Assumes clr_n is released
// synchronously enough for the system clock (release is not re-synchronized
// here; the top level owns that choice).
module shift_chain #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n,
    input  logic             shift_en,
    input  logic             d_in,
    output logic [WIDTH-1:0] stage_q
);
    // Shift on enable; clear at once on clr_n; zero on system reset.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)        stage_q <= '0;
        else if (!rst_n)   stage_q <= '0;
        else if (shift_en) stage_q <= {stage_q[WIDTH-2:0], d_in};
    end
endmodule

// File: rtl/hold_reg.sv
// Parallel holding register: copies the whole shift chain on load, and keeps
// its value otherwise. Assumes load is a single-cycle pulse.
module hold_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Capture the chain on load; zero on system reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/shreg_latch.sv
// Top of the serial-load shift register with holding register. The strobes
// and serial data are synchronized with matched depth, so the data sampled
// with a strobe edge is the value present when that strobe was first seen.
// The output enable only drives the per-bit drive-enable vector; the
// parallel data and the serial tap are never gated.
module shreg_latch
    import shreg_pkg::*;
#(
    parameter int WIDTH       = DEF_WIDTH,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n,
    input  logic             ser_in,
    input  logic             shift_strobe,
    input  logic             latch_strobe,
    input  logic             oe_n,
    output logic [WIDTH-1:0] par_data,
    output logic [WIDTH-1:0] par_drive,
    output logic             ser_out
);
    localparam int LAST = WIDTH - 1;

    logic             shift_pulse;
    logic             latch_pulse;
    logic             ser_aligned;
    logic [WIDTH-1:0] stage_q;
    logic [WIDTH-1:0] hold_q;

    strobe_sync #(.STAGES(SYNC_STAGES)) u_shift_sync (
        .clk(clk), .rst_n(rst_n), .strobe_in(shift_strobe), .pulse(shift_pulse)
    );

    strobe_sync #(.STAGES(SYNC_STAGES)) u_latch_sync (
        .clk(clk), .rst_n(rst_n), .strobe_in(latch_strobe), .pulse(latch_pulse)
    );

    bit_delay #(.DEPTH(SYNC_STAGES)) u_data_align (
        .clk(clk), .rst_n(rst_n), .d_in(ser_in), .d_out(ser_aligned)
    );

    shift_chain #(.WIDTH(WIDTH)) u_chain (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n),
        .shift_en(shift_pulse), .d_in(ser_aligned), .stage_q(stage_q)
    );

    hold_reg #(.WIDTH(WIDTH)) u_hold (
        .clk(clk), .rst_n(rst_n), .load(latch_pulse), .d(stage_q), .q(hold_q)
    );

    // Drive the bus outputs: data straight from the holding register,
    // enables as a whole-bus mask, serial tap from the last stage.
    always_comb begin
        par_data  = hold_q;
        par_drive = {WIDTH{~oe_n}};
        ser_out   = stage_q[LAST];
    end
endmodule

// File: rtl/shreg_latch_chk.sv
// Property checker for shreg_latch, attached through bind. It watches the
// synchronized pulses, the chain and the holding register together with the
// ports.
module shreg_latch_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_n,
    input logic             oe_n,
    input logic             shift_pulse,
    input logic             latch_pulse,
    input logic [WIDTH-1:0] stage_q,
    input logic [WIDTH-1:0] hold_q,
    input logic [WIDTH-1:0] par_data,
    input logic [WIDTH-1:0] par_drive,
    input logic             ser_out
);
    // R1: a shift moves every stage up by one place.
    p_shift_moves_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_pulse && clr_n) |=> (!clr_n || stage_q[WIDTH-1:1] == $past(stage_q[WIDTH-2:0])));

    // R2: the chain reads zero whenever the clear is held.
    p_clear_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> stage_q == '0);

    // R3: a latch pulse copies the chain as it stood at that edge.
    p_latch_copies_r3: assert property (@(posedge clk) disable iff (!rst_n)
        latch_pulse |=> hold_q == $past(stage_q));

    // R3: with no latch pulse the parallel word does not move.
    p_hold_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_pulse |=> $stable(par_data));

    // R4: drive enables cover the whole bus or none of it.
    p_drive_whole_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(par_drive) == 0) || ($countones(par_drive) == WIDTH));

    // R5: after a shift the serial tap shows the former next-to-last stage.
    p_tap_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_pulse && clr_n) |=> (!clr_n || ser_out == $past(stage_q[WIDTH-2])));

    // R9: each strobe edge yields a single-cycle pulse.
    p_shift_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        shift_pulse |=> !shift_pulse);

    p_latch_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        latch_pulse |=> !latch_pulse);
endmodule

bind shreg_latch shreg_latch_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .oe_n(oe_n),
    .shift_pulse(shift_pulse), .latch_pulse(latch_pulse),
    .stage_q(stage_q), .hold_q(hold_q),
    .par_data(par_data), .par_drive(par_drive), .ser_out(ser_out)
);

// File: tb/shreg_latch_test.sv
// Self-checking bench: walks a table of words through the block, then runs
// directed tests for reset, clear, overlapping strobes and held strobes.
module shreg_latch_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr_n = 1'b1;
    logic         ser_in = 1'b0;
    logic         shift_strobe = 1'b0;
    logic         latch_strobe = 1'b0;
    logic         oe_n = 1'b0;
    logic [W-1:0] par_data;
    logic [W-1:0] par_drive;
    logic         ser_out;

    int errors = 0;
    int checks = 0;
    bit q[$];                 // bits shifted since the last clear or reset
    logic [W-1:0] exp_hold = '0;

    // Table entries: {oe_n, word}
    localparam logic [W:0] VEC [6] = '{
        9'h0A5, 9'h15A, 9'h0FF, 9'h001, 9'h180, 9'h03C
    };

    always #2 clk = ~clk;     // 250 MHz

    shreg_latch uut (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ser_in(ser_in),
        .shift_strobe(shift_strobe), .latch_strobe(latch_strobe), .oe_n(oe_n),
        .par_data(par_data), .par_drive(par_drive), .ser_out(ser_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [W-1:0] model_chain();
        logic [W-1:0] v = '0;
        for (int i = 0; i < W; i++)
            if (q.size() > i) v[i] = q[q.size()-1-i];
        return v;
    endfunction

    function automatic logic model_tap();
        return (q.size() >= W) ? q[q.size()-W] : 1'b0;
    endfunction

    task automatic do_shift(input logic b);
        ser_in = b;
        shift_strobe = 1'b1;
        step(5);
        shift_strobe = 1'b0;
        step(4);
        q.push_back(b);
    endtask

    task automatic do_latch();
        latch_strobe = 1'b1;
        step(5);
        latch_strobe = 1'b0;
        step(4);
        exp_hold = model_chain();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R8: reset state
        step(4);
        @(negedge clk);
        chk("R8 reset par_data", par_data, 0);
        chk("R8 reset ser_out", ser_out, 0);
        chk("R4 drive with oe_n low", par_drive, 8'hFF);
        step(1);
        rst_n = 1'b1;
        step(2);

        // R1 R3 R4 R5: table walk, word sent from bit W-1 down to bit 0
        foreach (VEC[k]) begin
            for (int i = W-1; i >= 0; i--) begin
                do_shift(VEC[k][i]);
                @(negedge clk);
                chk("R5 tap equals bit from W shifts earlier", ser_out, model_tap());
                chk("R3 no latch keeps word", par_data, exp_hold);
            end
            oe_n = VEC[k][W];
            do_latch();
            @(negedge clk);
            chk("R1 R3 latched word", par_data, VEC[k][W-1:0]);
            chk("R4 drive follows oe_n", par_drive, VEC[k][W] ? 8'h00 : 8'hFF);
            chk("R5 tap ignores oe_n", ser_out, VEC[k][W-1]);
        end
        oe_n = 1'b0;

        // R6: both strobes rise together; chain holds 0x3C, next bit 1
        ser_in = 1'b1;
        shift_strobe = 1'b1;
        latch_strobe = 1'b1;
        step(5);
        shift_strobe = 1'b0;
        latch_strobe = 1'b0;
        step(4);
        q.push_back(1'b1);
        @(negedge clk);
        chk("R6 overlap captures pre-shift word", par_data, 8'h3C);
        do_latch();
        @(negedge clk);
        chk("R6 following latch sees shifted word", par_data, 8'h79);

        // R2 R7: load all ones, latch, then clear
        for (int i = 0; i < W; i++) do_shift(1'b1);
        do_latch();
        @(negedge clk);
        chk("R3 all ones latched", par_data, 8'hFF);
        step(1);
        clr_n = 1'b0;
        #1;
        chk("R2 clear empties tap without clock", ser_out, 0);
        chk("R2 clear leaves holding register", par_data, 8'hFF);
        do_shift(1'b1);       // must be ignored
        q.delete();
        clr_n = 1'b1;
        step(3);
        @(negedge clk);
        chk("R2 holding register still intact", par_data, 8'hFF);
        do_latch();
        @(negedge clk);
        chk("R7 shift during clear ignored", par_data, 8'h00);

        // R9: strobe held high for many cycles gives one shift
        ser_in = 1'b1;
        shift_strobe = 1'b1;
        step(30);
        shift_strobe = 1'b0;
        step(4);
        q.push_back(1'b1);
        do_latch();
        @(negedge clk);
        chk("R9 held strobe shifts once", par_data, 8'h01);

        // R8: mid-run synchronous reset
        for (int i = 0; i < W; i++) do_shift(1'b1);
        step(1);
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        q.delete();
        step(2);
        @(negedge clk);
        chk("R8 reset clears holding register", par_data, 8'h00);
        chk("R8 reset clears chain tap", ser_out, 0);
        do_latch();
        @(negedge clk);
        chk("R8 reset cleared chain", par_data, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule